// File: doc/BRIEF.md
# Detection Flag Bitmap Updater

This block holds one bit per range/Doppler cell of a radar frame in a word-organised RAM. Each detection result that reaches it (a valid strobe with a range bin, a Doppler bin and a flag) is folded into the map by a read-modify-write. The engine reads the word that holds the cell, replaces that single bit with the flag and writes the word back. The update is deliberately not pipelined. It takes a fixed three cycles, so the producer must not present results more often than once every third cycle. Anything offered while an update is in flight is discarded and counted.

A frame-clear request zeroes the map by writing every word address once, one per cycle. While this sweep runs the block accepts no results. A host read port returns one map word per request with one cycle of latency. The engine has first claim on the RAM read port, so a host request is served only when the engine is idle and is not starting an update in that same cycle.

Top module: `detmap_rmw`

## Requirements
- R1: After reset `busy` is low, `drop_count` is 0 and `host_rd_valid` is low.
- R2: The cell index is {range, doppler}. Its upper bits select the map word and its low log2(WORD_W) bits select the bit in that word. With the default widths the word address equals the range bin and the bit equals the Doppler bin. A flag of 1 sets that bit and leaves every other bit of the word unchanged.
- R3: A flag of 0 clears the addressed bit and leaves every other bit of the word unchanged.
- R4: A result is accepted in an idle cycle. `busy` is then high for exactly the next two cycles (read-wait, then write-back) and low on the third. The new word is visible to a read issued from that third cycle on.
- R5: A result offered while `busy` is high is discarded. It leaves the map unchanged and increments `drop_count` by one.
- R6: Results offered exactly once every three cycles are all applied, and none is counted as dropped.
- R7: A frame-clear request taken while idle starts a sweep that keeps `busy` high for 2^ADDR_W cycles and leaves every word zero. At the start of the sweep `drop_count` restarts from 0; a result offered in that first cycle counts as one drop. Results offered during the sweep are discarded and counted.
- R8: A frame-clear request raised while `busy` is high is held and starts its sweep at the next idle cycle.
- R9: `drop_count` is 16 bits wide and saturates at 65535.
- R10: A host read request is served when `busy` is low and no result is accepted in that cycle. The addressed word appears on `host_rd_data` one cycle later, with `host_rd_valid` high for that one cycle. A request that loses to an accepted result gives no `host_rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Detection result strobe |
| res_range | input | RANGE_W | Range bin of the result |
| res_doppler | input | DOPP_W | Doppler bin of the result |
| res_flag | input | 1 | Value written into the cell's bit |
| clear_req | input | 1 | Request to zero the whole map |
| host_rd_en | input | 1 | Host word read request |
| host_addr | input | ADDR_W | Host word address |
| host_rd_data | output | WORD_W | Map word read by the host |
| host_rd_valid | output | 1 | host_rd_data holds a served request |
| busy | output | 1 | Update or clear sweep in progress |
| drop_count | output | 16 | Saturating count of discarded results |

## Verification
The hardest condition to reach from the ports is counter saturation. It needs 65535 discarded results, while every third offered result is accepted and changes the map. The bench holds the result strobe high for about 99,000 cycles, so two of every three offers land in read-wait or write-back. A pending clear (R8) is reached by raising the clear request in the cycle right after an accepted result. Arbitration loss (R10) is reached by raising a host request and a result strobe in the same idle cycle.

// File: rtl/detmap_pkg.sv
// Shared types for the detection flag bitmap updater.
package detmap_pkg;

    // Engine state: idle, read-wait, write-back, clear sweep.
    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_RDWAIT = 2'd1,
        ENG_WRBACK = 2'd2,
        ENG_SWEEP  = 2'd3
    } eng_state_t;

endpackage

// File: rtl/detmap_ram.sv
// Map storage: one synchronous-read port, one write port.
// Assumes read data is used one cycle after the address is presented.
// The contents have no reset; a clear sweep initialises them.
module detmap_ram #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Registered read, plain write.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
        if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/detmap_engine.sv
// Read-modify-write engine with clear sweep and drop counter.
// An accepted result drives the read address in its idle cycle. The word is
// captured in read-wait and written back with one bit replaced in write-back.
// Results offered outside an accepting idle cycle are dropped and counted.
module detmap_engine
    import detmap_pkg::*;
#(
    parameter int CELL_W = 10,
    parameter int WORD_W = 16,
    parameter int BIT_W  = 4,
    parameter int ADDR_W = CELL_W - BIT_W,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CELL_W-1:0] cell_idx,
    input  logic              res_flag,
    input  logic              clear_req,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] eng_raddr,
    output logic              accept,
    output logic              busy,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  drop_cnt
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};

    eng_state_t        state;
    logic [ADDR_W-1:0] cap_addr;
    logic [BIT_W-1:0]  cap_bit;
    logic              cap_flag;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] merged;
    logic [ADDR_W-1:0] sweep_addr;
    logic              clear_pend;
    logic              clear_go;
    logic              drop;

    // Request decode for the current cycle.
    always_comb begin
        clear_go  = (state == ENG_IDLE) && (clear_req || clear_pend);
        accept    = (state == ENG_IDLE) && res_valid && !clear_go;
        drop      = res_valid && !accept;
        busy      = (state != ENG_IDLE);
        eng_raddr = cell_idx[CELL_W-1:BIT_W];
    end

    // Captured word with the target bit replaced by the flag.
    always_comb begin
        merged          = word_q;
        merged[cap_bit] = cap_flag;
    end

    // RAM write port: write-back or sweep.
    always_comb begin
        we    = (state == ENG_WRBACK) || (state == ENG_SWEEP);
        waddr = (state == ENG_SWEEP) ? sweep_addr : cap_addr;
        wdata = (state == ENG_SWEEP) ? '0 : merged;
    end

    // State sequencing, capture registers and sweep address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ENG_IDLE;
            cap_addr   <= '0;
            cap_bit    <= '0;
            cap_flag   <= 1'b0;
            word_q     <= '0;
            sweep_addr <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (clear_go) begin
                        sweep_addr <= '0;
                        state      <= ENG_SWEEP;
                    end else if (accept) begin
                        cap_addr <= cell_idx[CELL_W-1:BIT_W];
                        cap_bit  <= cell_idx[BIT_W-1:0];
                        cap_flag <= res_flag;
                        state    <= ENG_RDWAIT;
                    end
                end
                ENG_RDWAIT: begin
                    word_q <= rd_word;
                    state  <= ENG_WRBACK;
                end
                ENG_WRBACK: state <= ENG_IDLE;
                ENG_SWEEP: begin
                    sweep_addr <= sweep_addr + 1'b1;
                    if (sweep_addr == LAST_ADDR) begin
                        state <= ENG_IDLE;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Hold a clear request that arrives while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clear_pend <= 1'b0;
        end else if (clear_go) begin
            clear_pend <= 1'b0;
        end else if (clear_req) begin
            clear_pend <= 1'b1;
        end
    end

    // Saturating drop counter, restarted when a sweep begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_cnt <= '0;
        end else if (clear_go) begin
            drop_cnt <= {{(CNT_W-1){1'b0}}, res_valid};
        end else if (drop && drop_cnt != CNT_MAX) begin
            drop_cnt <= drop_cnt + 1'b1;
        end
    end

    // R4
    rdwait_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ENG_RDWAIT |=> state == ENG_WRBACK);

    // R4
    wrback_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ENG_WRBACK |=> state == ENG_IDLE);

    // R5
    drop_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && busy && drop_cnt != CNT_MAX) |=> drop_cnt == $past(drop_cnt) + 1'b1);

    // R9
    drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt == CNT_MAX && !clear_go) |=> drop_cnt == CNT_MAX);

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && busy && state != ENG_SWEEP) |=> (state != ENG_IDLE || clear_pend));
endmodule

// File: rtl/detmap_host_port.sv
// Read port arbitration between the engine and the host.
// Assumes the engine only needs the port in the idle cycle where it accepts.
// A host request is granted when the engine is idle and not accepting.
module detmap_host_port #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              eng_busy,
    input  logic              eng_accept,
    input  logic [ADDR_W-1:0] eng_raddr,
    output logic [ADDR_W-1:0] ram_raddr,
    output logic              host_rd_valid
);
    logic grant;

    // Address mux: the engine wins any conflict.
    always_comb begin
        grant     = host_rd_en && !eng_busy && !eng_accept;
        ram_raddr = grant ? host_addr : eng_raddr;
    end

    // Valid strobe matches the one-cycle RAM read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rd_valid <= 1'b0;
        end else begin
            host_rd_valid <= grant;
        end
    end

    // R10
    host_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_valid |-> $past(host_rd_en && !eng_busy));
endmodule

// File: rtl/detmap_rmw.sv
// Top level of the detection flag bitmap updater.
// Assumes results arrive no more than once every third cycle.
// Faster results are dropped and counted by design.
module detmap_rmw #(
    parameter int RANGE_W = 6,
    parameter int DOPP_W  = 4,
    parameter int WORD_W  = 16,
    parameter int CNT_W   = 16,
    parameter int BIT_W   = $clog2(WORD_W),
    parameter int CELL_W  = RANGE_W + DOPP_W,
    parameter int ADDR_W  = CELL_W - BIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               res_valid,
    input  logic [RANGE_W-1:0] res_range,
    input  logic [DOPP_W-1:0]  res_doppler,
    input  logic               res_flag,
    input  logic               clear_req,
    input  logic               host_rd_en,
    input  logic [ADDR_W-1:0]  host_addr,
    output logic [WORD_W-1:0]  host_rd_data,
    output logic               host_rd_valid,
    output logic               busy,
    output logic [CNT_W-1:0]   drop_count
);
    logic [CELL_W-1:0] cell_idx;
    logic [ADDR_W-1:0] eng_raddr;
    logic [ADDR_W-1:0] ram_raddr;
    logic [ADDR_W-1:0] waddr;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] rdata;
    logic              accept;
    logic              we;

    assign cell_idx     = {res_range, res_doppler};
    assign host_rd_data = rdata;

    detmap_engine #(
        .CELL_W(CELL_W), .WORD_W(WORD_W), .BIT_W(BIT_W),
        .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) engine_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .cell_idx(cell_idx),
        .res_flag(res_flag), .clear_req(clear_req), .rd_word(rdata),
        .eng_raddr(eng_raddr), .accept(accept), .busy(busy), .we(we),
        .waddr(waddr), .wdata(wdata), .drop_cnt(drop_count)
    );

    detmap_host_port #(.ADDR_W(ADDR_W)) port_i (
        .clk(clk), .rst_n(rst_n), .host_rd_en(host_rd_en), .host_addr(host_addr),
        .eng_busy(busy), .eng_accept(accept), .eng_raddr(eng_raddr),
        .ram_raddr(ram_raddr), .host_rd_valid(host_rd_valid)
    );

    detmap_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) ram_i (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(ram_raddr), .rdata(rdata)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && drop_count == '0 && !host_rd_valid));
endmodule

// File: tb/detmap_rmw_tb_top.sv
`timescale 1ns / 1ps
// Self-checking bench for detmap_rmw with default parameters.
module detmap_rmw_tb_top;
    typedef struct packed {
        logic [5:0]  rng;
        logic [3:0]  dop;
        logic        flg;
        logic [15:0] exp;
    } vec_t;

    // Stimulus and the expected word (address = range) after each update.
    localparam vec_t VEC [12] = '{
        '{6'd5,  4'd0,  1'b1, 16'h0001},
        '{6'd5,  4'd15, 1'b1, 16'h8001},
        '{6'd5,  4'd7,  1'b1, 16'h8081},
        '{6'd5,  4'd0,  1'b0, 16'h8080},
        '{6'd0,  4'd3,  1'b1, 16'h0008},
        '{6'd63, 4'd9,  1'b1, 16'h0200},
        '{6'd63, 4'd9,  1'b1, 16'h0200},
        '{6'd0,  4'd3,  1'b0, 16'h0000},
        '{6'd5,  4'd15, 1'b0, 16'h0080},
        '{6'd40, 4'd1,  1'b0, 16'h0000},
        '{6'd40, 4'd2,  1'b1, 16'h0004},
        '{6'd63, 4'd0,  1'b1, 16'h0201}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [5:0]  res_range = '0;
    logic [3:0]  res_doppler = '0;
    logic        res_flag = 1'b0;
    logic        clear_req = 1'b0;
    logic        host_rd_en = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_rd_data;
    logic        host_rd_valid;
    logic        busy;
    logic [15:0] drop_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    detmap_rmw dut_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_range(res_range),
        .res_doppler(res_doppler), .res_flag(res_flag), .clear_req(clear_req),
        .host_rd_en(host_rd_en), .host_addr(host_addr), .host_rd_data(host_rd_data),
        .host_rd_valid(host_rd_valid), .busy(busy), .drop_count(drop_count)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One result, then two quiet cycles: a three-cycle cadence.
    task automatic send(input logic [5:0] r, input logic [3:0] d, input logic f);
        res_valid = 1'b1; res_range = r; res_doppler = d; res_flag = f;
        @(negedge clk);
        res_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic host_read(input logic [5:0] a, input logic [15:0] exp, input string tag);
        host_rd_en = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd_en = 1'b0;
        check({tag, " valid"}, {31'd0, host_rd_valid}, 32'd1);
        check({tag, " word"}, {16'd0, host_rd_data}, {16'd0, exp});
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    endtask

    task automatic do_clear(output int cycles);
        clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        cycles = 0;
        while (busy && cycles < 1000) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R4 engine hang actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 drop_count", {16'd0, drop_count}, 32'd0);
        check("R1 host_rd_valid", {31'd0, host_rd_valid}, 32'd0);

        // R7 sweep length and zeroed map
        do_clear(n);
        check("R7 sweep cycles", n, 64);
        for (int a = 0; a < 64; a++) host_read(a[5:0], 16'h0000, "R7 cleared");

        // R2 R3 table walk with read-back after each update
        for (int i = 0; i < 12; i++) begin
            send(VEC[i].rng, VEC[i].dop, VEC[i].flg);
            host_read(VEC[i].rng, VEC[i].exp, VEC[i].flg ? "R2 set" : "R3 clear");
        end

        // R4 busy profile of one update
        res_valid = 1'b1; res_range = 6'd20; res_doppler = 4'd6; res_flag = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        check("R4 busy c1", {31'd0, busy}, 32'd1);
        @(negedge clk);
        check("R4 busy c2", {31'd0, busy}, 32'd1);
        @(negedge clk);
        check("R4 busy c3", {31'd0, busy}, 32'd0);
        host_read(6'd20, 16'h0040, "R4 written");

        // R6 back-to-back at three-cycle cadence
        do_clear(n);
        for (int i = 0; i < 12; i++) send(VEC[i].rng, VEC[i].dop, VEC[i].flg);
        check("R6 no drops", {16'd0, drop_count}, 32'd0);
        host_read(6'd5, 16'h0080, "R6 w5");
        host_read(6'd0, 16'h0000, "R6 w0");
        host_read(6'd63, 16'h0201, "R6 w63");
        host_read(6'd40, 16'h0004, "R6 w40");

        // R5 results in read-wait and write-back are dropped
        res_valid = 1'b1; res_range = 6'd10; res_doppler = 4'd1; res_flag = 1'b1;
        @(negedge clk);
        res_doppler = 4'd2;
        @(negedge clk);
        res_range = 6'd11; res_doppler = 4'd0;
        @(negedge clk);
        res_valid = 1'b0;
        check("R5 drop_count", {16'd0, drop_count}, 32'd2);
        host_read(6'd10, 16'h0002, "R5 w10");
        host_read(6'd11, 16'h0000, "R5 w11");

        // R10 host request loses to an accepted result
        res_valid = 1'b1; res_range = 6'd12; res_doppler = 4'd3; res_flag = 1'b1;
        host_rd_en = 1'b1; host_addr = 6'd5;
        @(negedge clk);
        res_valid = 1'b0; host_rd_en = 1'b0;
        check("R10 no grant", {31'd0, host_rd_valid}, 32'd0);
        @(negedge clk);
        @(negedge clk);
        host_read(6'd12, 16'h0008, "R10 w12");

        // R7 counter restart and drops during the sweep
        clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        res_valid = 1'b1; res_range = 6'd30; res_doppler = 4'd0; res_flag = 1'b1;
        repeat (5) @(negedge clk);
        res_valid = 1'b0;
        wait_idle();
        check("R7 sweep drops", {16'd0, drop_count}, 32'd5);
        host_read(6'd30, 16'h0000, "R7 w30");
        host_read(6'd10, 16'h0000, "R7 w10");

        // R8 clear raised during an update is held
        send(6'd10, 4'd4, 1'b1);
        res_valid = 1'b1; res_range = 6'd9; res_doppler = 4'd4; res_flag = 1'b1;
        @(negedge clk);
        res_valid = 1'b0; clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 sweep running", {31'd0, busy}, 32'd1);
        wait_idle();
        host_read(6'd10, 16'h0000, "R8 w10");
        host_read(6'd9, 16'h0000, "R8 w9");
        check("R8 drop_count", {16'd0, drop_count}, 32'd0);

        // R9 saturation under a constant strobe
        res_valid = 1'b1; res_range = 6'd1; res_doppler = 4'd1; res_flag = 1'b1;
        repeat (99000) @(negedge clk);
        res_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 saturated", {16'd0, drop_count}, 32'd65535);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule